// File: doc/BRIEF.md
# Region Access Evaluator for Memory Protection

This block decides, in a single combinational pass, whether one bus access falls under one protection region, and whether that access must be refused. The caller supplies the requesting master number, the access direction, and the process identifier that is currently running. The caller also supplies the stored contents of one region entry: a valid flag, an 8-bit identifier with an 8-bit mask, a per-master identifier-enable vector, and per-master read and write permission vectors. The address-range comparison happens outside this block and arrives as one in-range bit.

The block has two outputs. A region hit needs a valid entry and an in-range address. If the identifier check is enabled for the requesting master, the hit also needs the running identifier to equal the stored one on every bit that the mask leaves unmasked. When the region hits and the master lacks permission for the direction it asked for, the error output rises. The surrounding fabric must then end that transfer with an error and must not carry out the read or write. Masters below a fixed threshold (0 to 3 by default) always have full permission. A wider system combines the verdicts of several such evaluators, one per region entry.

Top module: `mpu_access_eval`

## Requirements
- R1: When `desc_valid` is 0, `region_hit` and `access_err` are both 0, whatever the other inputs are.
- R2: When `in_range` is 0, `region_hit` and `access_err` are both 0.
- R3: When bit `acc_master` of `proc_en` is 0, `acc_pid` and the stored identifier and mask have no effect. In that case `region_hit` equals `desc_valid AND in_range`.
- R4: When bit `acc_master` of `proc_en` is 1, the region hits only if `acc_pid` equals `desc_pid` on every bit position where `desc_pid_mask` is 0. A single differing unmasked bit prevents the hit.
- R5: A 1 in bit k of `desc_pid_mask` makes bit k of the identifiers irrelevant. An all-ones mask matches any `acc_pid`.
- R6: A read (`acc_write` = 0) by master 4 to 7 that hits, with bit `acc_master` of `rd_en` at 0, raises `access_err`. With that bit at 1 there is no error.
- R7: A write (`acc_write` = 1) by master 4 to 7 that hits, with bit `acc_master` of `wr_en` at 0, raises `access_err`. With that bit at 1 there is no error.
- R8: Masters 0 to 3 never produce `access_err`. Bits 0 to 3 of `rd_en` and `wr_en` have no effect.
- R9: `access_err` is 1 only while `region_hit` is 1. A read depends only on `rd_en` and a write depends only on `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_master | input | 3 | Number of the requesting master |
| acc_write | input | 1 | Access direction: 0 read, 1 write |
| acc_pid | input | 8 | Process identifier currently running |
| in_range | input | 1 | Address lies inside the region (computed outside) |
| desc_valid | input | 1 | Region entry is valid |
| desc_pid | input | 8 | Stored process identifier |
| desc_pid_mask | input | 8 | Stored identifier mask; 1 = bit ignored |
| proc_en | input | 8 | Per-master enable of the identifier check |
| rd_en | input | 8 | Per-master read permission |
| wr_en | input | 8 | Per-master write permission |
| region_hit | output | 1 | Access falls under this region |
| access_err | output | 1 | Access must be refused and not performed |

## Verification
The block holds no state, so every fault appears at the outputs in the same cycle as the stimulus that exposes it. A bad bit in the masked compare shows only when the two identifiers differ on that bit, the mask leaves it open, and the check is enabled for the master. A wrong permission lookup shows as an error raised or lost for one master and one direction only. For that reason the stimulus pairs each master with both directions and with single-bit identifier differences, as well as the broad cases.

// File: rtl/mpu_eval_pkg.sv
package mpu_eval_pkg;

    localparam int NUM_MASTERS         = 8;
    localparam int PID_W               = 8;
    localparam int FULL_ACCESS_MASTERS = 4;
    localparam int MASTER_W            = $clog2(NUM_MASTERS);

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_kind_e;

    // Identifier-related part of a region entry
    typedef struct packed {
        logic             valid;
        logic [PID_W-1:0] pid;
        logic [PID_W-1:0] pid_mask;
    } desc_id_t;

    // Outcome of one evaluation
    typedef struct packed {
        logic hit;
        logic err;
    } verdict_t;

    // Equality restricted to the bits the mask leaves open
    function automatic logic pid_equal_masked(
        input logic [PID_W-1:0] running,
        input logic [PID_W-1:0] stored,
        input logic [PID_W-1:0] ignore
    );
        return ~|((running ^ stored) & ~ignore);
    endfunction

endpackage

// File: rtl/mpu_pid_compare.sv
module mpu_pid_compare
    import mpu_eval_pkg::*;
#(
    parameter int W = PID_W
) (
    input  logic [W-1:0] running_pid,
    input  logic [W-1:0] stored_pid,
    input  logic [W-1:0] ignore_mask,
    output logic         pid_match
);

    logic [W-1:0] bit_ok;

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            assign bit_ok[b] = ignore_mask[b] | ~(running_pid[b] ^ stored_pid[b]);
        end
    endgenerate

    assign pid_match = &bit_ok;

endmodule

// File: rtl/mpu_perm_lookup.sv
module mpu_perm_lookup
    import mpu_eval_pkg::*;
#(
    parameter int N_MST    = NUM_MASTERS,
    parameter int N_FULL   = FULL_ACCESS_MASTERS,
    parameter int MST_W    = MASTER_W
) (
    input  logic [MST_W-1:0] master,
    input  acc_kind_e        kind,
    input  logic [N_MST-1:0] proc_en,
    input  logic [N_MST-1:0] rd_en,
    input  logic [N_MST-1:0] wr_en,
    output logic             allowed,
    output logic             pid_required
);

    logic [N_MST-1:0] allow_vec;

    generate
        for (genvar m = 0; m < N_MST; m++) begin : g_mst
            if (m < N_FULL) begin : g_full
                assign allow_vec[m] = 1'b1;
            end else begin : g_ctl
                assign allow_vec[m] = (kind == ACC_WRITE) ? wr_en[m] : rd_en[m];
            end
        end
    endgenerate

    always_comb begin
        allowed      = 1'b0;
        pid_required = 1'b0;
        if (int'(master) < N_MST) begin
            allowed      = allow_vec[master];
            pid_required = proc_en[master];
        end
    end

endmodule

// File: rtl/mpu_hit_resolve.sv
module mpu_hit_resolve
    import mpu_eval_pkg::*;
(
    input  logic     entry_valid,
    input  logic     addr_in_range,
    input  logic     pid_match,
    input  logic     pid_required,
    input  logic     allowed,
    output verdict_t verdict
);

    always_comb begin
        verdict.hit = entry_valid & addr_in_range & (pid_match | ~pid_required);
        verdict.err = verdict.hit & ~allowed;
    end

endmodule

// File: rtl/mpu_access_eval.sv
module mpu_access_eval
    import mpu_eval_pkg::*;
#(
    parameter int N_MST  = NUM_MASTERS,
    parameter int N_FULL = FULL_ACCESS_MASTERS,
    parameter int PW     = PID_W,
    localparam int MST_W = $clog2(N_MST)
) (
    input  logic [MST_W-1:0] acc_master,
    input  logic             acc_write,
    input  logic [PW-1:0]    acc_pid,
    input  logic             in_range,
    input  logic             desc_valid,
    input  logic [PW-1:0]    desc_pid,
    input  logic [PW-1:0]    desc_pid_mask,
    input  logic [N_MST-1:0] proc_en,
    input  logic [N_MST-1:0] rd_en,
    input  logic [N_MST-1:0] wr_en,
    output logic             region_hit,
    output logic             access_err
);

    acc_kind_e kind;
    logic      pid_match;
    logic      allowed;
    logic      pid_required;
    verdict_t  verdict;

    assign kind = acc_write ? ACC_WRITE : ACC_READ;

    mpu_pid_compare #(.W(PW)) i_pid (
        .running_pid (acc_pid),
        .stored_pid  (desc_pid),
        .ignore_mask (desc_pid_mask),
        .pid_match   (pid_match)
    );

    mpu_perm_lookup #(.N_MST(N_MST), .N_FULL(N_FULL), .MST_W(MST_W)) i_perm (
        .master       (acc_master),
        .kind         (kind),
        .proc_en      (proc_en),
        .rd_en        (rd_en),
        .wr_en        (wr_en),
        .allowed      (allowed),
        .pid_required (pid_required)
    );

    mpu_hit_resolve i_resolve (
        .entry_valid   (desc_valid),
        .addr_in_range (in_range),
        .pid_match     (pid_match),
        .pid_required  (pid_required),
        .allowed       (allowed),
        .verdict       (verdict)
    );

    assign region_hit = verdict.hit;
    assign access_err = verdict.err;

endmodule

// File: rtl/mpu_access_eval_chk.sv
module mpu_access_eval_chk #(
    parameter int N_MST  = 8,
    parameter int N_FULL = 4,
    parameter int PW     = 8,
    localparam int MST_W = $clog2(N_MST)
) (
    input logic [MST_W-1:0] acc_master,
    input logic             acc_write,
    input logic [PW-1:0]    acc_pid,
    input logic             in_range,
    input logic             desc_valid,
    input logic [PW-1:0]    desc_pid,
    input logic [PW-1:0]    desc_pid_mask,
    input logic [N_MST-1:0] proc_en,
    input logic [N_MST-1:0] rd_en,
    input logic [N_MST-1:0] wr_en,
    input logic             region_hit,
    input logic             access_err
);

    always_comb begin
        // R1
        hit_needs_valid_chk: assert (desc_valid || !region_hit);
        // R2
        hit_needs_range_chk: assert (in_range || !region_hit);
        // R9
        err_needs_hit_chk: assert (region_hit || !access_err);
        // R8
        low_master_no_err_chk: assert (int'(acc_master) >= N_FULL || !access_err);
        // R4
        pid_gate_chk: assert (!(region_hit && proc_en[acc_master])
                              || (((acc_pid ^ desc_pid) & ~desc_pid_mask) == '0));
        // R3
        pid_off_hit_chk: assert (proc_en[acc_master] || (region_hit == (desc_valid && in_range)));
        // R6
        read_denied_chk: assert (!(region_hit && !acc_write && int'(acc_master) >= N_FULL
                                   && !rd_en[acc_master]) || access_err);
        // R7
        write_denied_chk: assert (!(region_hit && acc_write && int'(acc_master) >= N_FULL
                                    && !wr_en[acc_master]) || access_err);
    end

endmodule

bind mpu_access_eval mpu_access_eval_chk #(.N_MST(N_MST), .N_FULL(N_FULL), .PW(PW)) i_chk (
    .acc_master    (acc_master),
    .acc_write     (acc_write),
    .acc_pid       (acc_pid),
    .in_range      (in_range),
    .desc_valid    (desc_valid),
    .desc_pid      (desc_pid),
    .desc_pid_mask (desc_pid_mask),
    .proc_en       (proc_en),
    .rd_en         (rd_en),
    .wr_en         (wr_en),
    .region_hit    (region_hit),
    .access_err    (access_err)
);

// File: tb/test_mpu_access_eval.sv
module test_mpu_access_eval;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] acc_master = '0;
    logic       acc_write = 1'b0;
    logic [7:0] acc_pid = '0;
    logic       in_range = 1'b0;
    logic       desc_valid = 1'b0;
    logic [7:0] desc_pid = '0;
    logic [7:0] desc_pid_mask = '0;
    logic [7:0] proc_en = '0;
    logic [7:0] rd_en = '0;
    logic [7:0] wr_en = '0;
    logic       region_hit;
    logic       access_err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        string tag;
        logic  hit;
        logic  err;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mpu_access_eval i_mpu_access_eval (
        .acc_master    (acc_master),
        .acc_write     (acc_write),
        .acc_pid       (acc_pid),
        .in_range      (in_range),
        .desc_valid    (desc_valid),
        .desc_pid      (desc_pid),
        .desc_pid_mask (desc_pid_mask),
        .proc_en       (proc_en),
        .rd_en         (rd_en),
        .wr_en         (wr_en),
        .region_hit    (region_hit),
        .access_err    (access_err)
    );

    // Reference written from the requirements, bit by bit
    task automatic predict(output logic h, output logic e);
        logic ok;
        h = desc_valid && in_range;
        if (proc_en[acc_master]) begin
            for (int b = 0; b < 8; b++) begin
                if (!desc_pid_mask[b] && (acc_pid[b] != desc_pid[b])) h = 1'b0;
            end
        end
        if (acc_master < 3'd4) ok = 1'b1;
        else if (acc_write)    ok = wr_en[acc_master];
        else                   ok = rd_en[acc_master];
        e = h && !ok;
    endtask

    task automatic drive(input string tag, input logic [2:0] m, input logic w,
                         input logic [7:0] pid, input logic inr, input logic v,
                         input logic [7:0] dp, input logic [7:0] dm,
                         input logic [7:0] pe, input logic [7:0] rd, input logic [7:0] wr);
        exp_t it;
        @(posedge clk);
        #1;
        acc_master = m; acc_write = w; acc_pid = pid; in_range = inr;
        desc_valid = v; desc_pid = dp; desc_pid_mask = dm;
        proc_en = pe; rd_en = rd; wr_en = wr;
        it.tag = tag;
        predict(it.hit, it.err);
        sb.push_back(it);
    endtask

    // Monitor: compares away from the rising edge
    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            n_run++;
            if (region_hit !== it.hit || access_err !== it.err) begin
                n_fail++;
                $display("FAIL %s: hit/err actual %b/%b expected %b/%b",
                         it.tag, region_hit, access_err, it.hit, it.err);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state: all inputs zero
        drive("R1 reset", 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        // R1 invalid entry, everything else matching
        drive("R1 invalid", 3'd5, 1'b0, 8'h3C, 1'b1, 1'b0, 8'h3C, 8'h00, 8'hFF, 8'h00, 8'h00);
        // R2 out of range
        drive("R2 range", 3'd6, 1'b1, 8'h11, 1'b0, 1'b1, 8'h11, 8'h00, 8'h00, 8'h00, 8'h00);
        // R3 identifier mismatch ignored when check disabled
        drive("R3 pid off", 3'd4, 1'b0, 8'hAA, 1'b1, 1'b1, 8'h55, 8'h00, 8'hEF, 8'hFF, 8'hFF);
        // R4 full match
        drive("R4 match", 3'd4, 1'b0, 8'h5A, 1'b1, 1'b1, 8'h5A, 8'h00, 8'h10, 8'hFF, 8'hFF);
        // R4 single-bit differences on each position
        for (int b = 0; b < 8; b++)
            drive("R4 one bit", 3'd7, 1'b1, 8'hC3 ^ (8'h01 << b), 1'b1, 1'b1, 8'hC3, 8'h00,
                  8'h80, 8'hFF, 8'hFF);
        // R5 all-ones mask
        drive("R5 all mask", 3'd1, 1'b0, 8'h00, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00);
        // R5 partial mask hides difference
        drive("R5 masked", 3'd5, 1'b1, 8'hF0, 1'b1, 1'b1, 8'h00, 8'hF0, 8'h20, 8'h00, 8'hFF);
        // R5 partial mask leaves an open differing bit
        drive("R5 open", 3'd5, 1'b1, 8'hF1, 1'b1, 1'b1, 8'h00, 8'hF0, 8'h20, 8'h00, 8'hFF);
        // R6 read denied / allowed
        drive("R6 rd deny", 3'd5, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'hDF, 8'hFF);
        drive("R6 rd ok", 3'd5, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h20, 8'h00);
        // R7 write denied / allowed
        drive("R7 wr deny", 3'd6, 1'b1, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hBF);
        drive("R7 wr ok", 3'd6, 1'b1, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h40);
        // R8 low masters with no permission bits
        for (int m = 0; m < 4; m++) begin
            drive("R8 low rd", 3'(m), 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
            drive("R8 low wr", 3'(m), 1'b1, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        end
        // R9 no error without hit, even with no permission
        drive("R9 nohit", 3'd7, 1'b1, 8'h01, 1'b1, 1'b1, 8'h02, 8'h00, 8'h80, 8'h00, 8'h00);
        // R9 direction isolation
        drive("R9 rd iso", 3'd6, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h40, 8'h00);
        drive("R9 wr iso", 3'd6, 1'b1, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h40);
        // Sweep: every master and direction, one-hot permissions
        for (int m = 0; m < 8; m++)
            for (int w = 0; w < 2; w++)
                for (int p = 0; p < 8; p++)
                    drive("R6 R7 sweep", 3'(m), 1'(w), 8'h00, 1'b1, 1'b1, 8'h00, 8'h00,
                          8'h00, 8'h01 << p, 8'h80 >> p);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule